// File: doc/BRIEF.md
# Postfix Text Word Loader

This block turns a stream of ASCII bytes into program words for a small processor and writes them into its program memory. The text is postfix: a decimal operand is typed first and a single opcode character follows it and completes the word. The operand fills the low bits of the word and the opcode character, reduced to its low five bits, fills the high bits. Each finished word goes to the current load address, which then advances by one.

Three lowercase commands act on the number typed before them. One moves the load address. One presets the attached core's program counter. One asks the core to execute a single instruction. Whitespace discards a partly typed number. Every other byte is dropped. All outputs are registered and change one clock after the byte is accepted.

Top module: `postfix_loader`

## Requirements
- R1: After reset `mem_we`, `pc_load` and `step_pulse` are low, `pc_value` is 0, `in_ready` is high and the first word goes to address 0.
- R2: Each accepted digit byte `0`..`9` updates the pending number to (number*10 + digit) modulo 2^OPND_W (2048 by default) and raises no output strobe.
- R3: An accepted byte in 0x40..0x5F raises `mem_we` for exactly the next cycle, with `mem_wdata` = {byte[4:0], number} (opcode in bits 15:11, number in bits 10:0), so `@` gives opcode 0 and `_` gives opcode 31.
- R4: `mem_addr` of a write equals the load address, which then advances by one and wraps from 2^ADDR_W-1 to 0.
- R5: The pending number returns to 0 after each written word, so an opcode byte with no digits before it writes number 0.
- R6: Byte `a` (0x61) sets the load address to the pending number, writes nothing and clears the number.
- R7: Byte `e` (0x65) raises `pc_load` for one cycle with `pc_value` equal to the pending number and clears the number; `pc_value` changes at no other time.
- R8: Byte `s` (0x73) raises `step_pulse` for one cycle and clears the pending number.
- R9: Space (0x20), carriage return (0x0D) and line feed (0x0A) clear the pending number and raise no strobe.
- R10: Any other byte, and any byte while `in_valid` is low, leaves the pending number and load address unchanged and raises no strobe.
- R11: At most one of `mem_we`, `pc_load`, `step_pulse` is high in a cycle, and none is high unless a byte was accepted at the edge before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Incoming ASCII byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Byte accepted when high together with `in_valid` |
| mem_we | output | 1 | Program memory write strobe |
| mem_addr | output | ADDR_W | Program memory write address |
| mem_wdata | output | 5+OPND_W | Word written to memory |
| pc_load | output | 1 | Preset strobe for the core's program counter |
| pc_value | output | ADDR_W | Program counter preset value |
| step_pulse | output | 1 | Single step request to the core |

## Verification
The bench sweeps all 32 opcode characters, each with its own operand. The operands include values above 2047, to catch an accumulator that saturates or keeps extra bits instead of wrapping. It sets the load address to the top address and writes past it: a design that does not wrap there, or that advances on a command byte, puts words at the wrong address. It puts stray bytes between digits, and whitespace before a number. A design that resets the number on stray bytes would write a different operand, and one that keeps digits across whitespace would do the same. Between bytes it holds an opcode character on the bus with `in_valid` low, which catches a design that ignores the handshake. It also sends a bare opcode and bare commands, to show that the number was cleared by the previous word.

// File: rtl/loader_pkg.sv
package loader_pkg;

  localparam int OPC_W = 5;

  typedef enum logic [2:0] {
    CH_DIGIT,
    CH_OPCODE,
    CH_SETADDR,
    CH_SETPC,
    CH_STEP,
    CH_SEP,
    CH_OTHER
  } char_kind_t;

  function automatic char_kind_t classify(input logic [7:0] ch);
    char_kind_t k;
    if (ch >= 8'h30 && ch <= 8'h39)  k = CH_DIGIT;
    else if (ch[7:5] == 3'b010)      k = CH_OPCODE;
    else begin
      case (ch)
        8'h61:                   k = CH_SETADDR;
        8'h65:                   k = CH_SETPC;
        8'h73:                   k = CH_STEP;
        8'h20, 8'h0D, 8'h0A:     k = CH_SEP;
        default:                 k = CH_OTHER;
      endcase
    end
    return k;
  endfunction

  // decimal shift-in on a 32-bit working value; callers keep the low bits
  function automatic logic [31:0] dec_push(input logic [31:0] acc, input logic [3:0] d);
    return (acc * 32'd10) + {28'd0, d};
  endfunction

endpackage

// File: rtl/loader_char_decode.sv
module loader_char_decode
  import loader_pkg::*;
(
  input  logic [7:0]       ch,
  output char_kind_t       kind,
  output logic [3:0]       digit,
  output logic [OPC_W-1:0] opcode
);
  assign kind   = classify(ch);
  assign digit  = ch[3:0];
  assign opcode = ch[OPC_W-1:0];
endmodule

// File: rtl/loader_operand.sv
module loader_operand
  import loader_pkg::*;
#(
  parameter int OPND_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  char_kind_t        kind,
  input  logic [3:0]        digit,
  output logic [OPND_W-1:0] operand
);
  logic [31:0] widened;
  logic [31:0] pushed;

  assign widened = {{(32-OPND_W){1'b0}}, operand};
  assign pushed  = dec_push(widened, digit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand <= '0;
    end else if (accept) begin
      case (kind)
        CH_DIGIT: operand <= pushed[OPND_W-1:0];
        CH_OTHER: operand <= operand;
        default:  operand <= '0;
      endcase
    end
  end

  // R9
  num_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind != CH_DIGIT && kind != CH_OTHER) |=> (operand == '0));

  // R10
  num_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept || kind == CH_OTHER) |=> $stable(operand));
endmodule

// File: rtl/loader_wr_seq.sv
module loader_wr_seq
  import loader_pkg::*;
#(
  parameter int OPND_W = 11,
  parameter int ADDR_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  char_kind_t              kind,
  input  logic [OPC_W-1:0]        opcode,
  input  logic [OPND_W-1:0]       operand,
  input  logic [ADDR_W-1:0]       operand_addr,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [OPC_W+OPND_W-1:0] mem_wdata
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] load_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_addr <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (accept) begin
        case (kind)
          CH_OPCODE: begin
            mem_we    <= 1'b1;
            mem_addr  <= load_addr;
            mem_wdata <= {opcode, operand};
            load_addr <= load_addr + ADDR_ONE;
          end
          CH_SETADDR: load_addr <= operand_addr;
          default: ;
        endcase
      end
    end
  end

  // R3
  wr_only_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind != CH_OPCODE) |=> !mem_we);

  // R3
  wr_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == CH_OPCODE) |=>
      (mem_we && mem_wdata[OPND_W-1:0] == $past(operand)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && accept && kind == CH_OPCODE) |=>
      (mem_addr == $past(mem_addr) + ADDR_ONE));
endmodule

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import loader_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  char_kind_t        kind,
  input  logic [ADDR_W-1:0] operand_addr,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value,
  output logic              step_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load    <= 1'b0;
      pc_value   <= '0;
      step_pulse <= 1'b0;
    end else begin
      pc_load    <= 1'b0;
      step_pulse <= 1'b0;
      if (accept) begin
        case (kind)
          CH_SETPC: begin
            pc_load  <= 1'b1;
            pc_value <= operand_addr;
          end
          CH_STEP: step_pulse <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load |-> $stable(pc_value));

  // R8
  step_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> ($past(accept) && $past(kind) == CH_STEP));
endmodule

// File: rtl/postfix_loader.sv
module postfix_loader
  import loader_pkg::*;
#(
  parameter int OPND_W = 11,
  parameter int ADDR_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [OPC_W+OPND_W-1:0] mem_wdata,
  output logic                    pc_load,
  output logic [ADDR_W-1:0]       pc_value,
  output logic                    step_pulse
);
  logic              accept;
  char_kind_t        kind;
  logic [3:0]        digit;
  logic [OPC_W-1:0]  opcode;
  logic [OPND_W-1:0] operand;
  logic [ADDR_W-1:0] operand_addr;

  assign in_ready = 1'b1;
  assign accept   = in_valid & in_ready;

  loader_char_decode u_dec (
    .ch     (in_data),
    .kind   (kind),
    .digit  (digit),
    .opcode (opcode)
  );

  loader_operand #(.OPND_W(OPND_W)) u_num (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .kind    (kind),
    .digit   (digit),
    .operand (operand)
  );

  // number reused as an address: widen or cut to the address width
  generate
    if (ADDR_W > OPND_W) begin : g_widen
      assign operand_addr = {{(ADDR_W-OPND_W){1'b0}}, operand};
    end else if (ADDR_W == OPND_W) begin : g_same
      assign operand_addr = operand;
    end else begin : g_cut
      assign operand_addr = operand[ADDR_W-1:0];
    end
  endgenerate

  loader_wr_seq #(.OPND_W(OPND_W), .ADDR_W(ADDR_W)) u_wr (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .kind         (kind),
    .opcode       (opcode),
    .operand      (operand),
    .operand_addr (operand_addr),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata)
  );

  loader_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .kind         (kind),
    .operand_addr (operand_addr),
    .pc_load      (pc_load),
    .pc_value     (pc_value),
    .step_pulse   (step_pulse)
  );

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, pc_load, step_pulse}));

  // R11
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !(mem_we || pc_load || step_pulse));
endmodule

// File: tb/postfix_loader_test.sv
`timescale 1ns/1ps
module postfix_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        mem_we;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        pc_load;
  logic [10:0] pc_value;
  logic        step_pulse;

  int checks = 0;
  int errors = 0;
  int exp_num = 0;
  int exp_addr = 0;
  int exp_pc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  postfix_loader uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_value(pc_value),
    .step_pulse(step_pulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input byte c);
    int we_e, pl_e, st_e;
    string tag;
    we_e = 0; pl_e = 0; st_e = 0; tag = "R10";
    @(negedge clk);
    in_data  = c;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    if (c >= "0" && c <= "9") begin
      tag = "R2";
      exp_num = (exp_num * 10 + (c - 8'h30)) % 2048;
    end else if (c >= 8'h40 && c <= 8'h5F) begin
      tag = "R3"; we_e = 1;
      chk("R4", "mem_addr", int'(mem_addr), exp_addr);
      chk("R3", "mem_wdata", int'(mem_wdata), (c % 32) * 2048 + exp_num);
      exp_addr = (exp_addr + 1) % 2048;
      exp_num = 0;
    end else if (c == "a") begin
      tag = "R6"; exp_addr = exp_num; exp_num = 0;
    end else if (c == "e") begin
      tag = "R7"; pl_e = 1; exp_pc = exp_num; exp_num = 0;
    end else if (c == "s") begin
      tag = "R8"; st_e = 1; exp_num = 0;
    end else if (c == 8'h20 || c == 8'h0D || c == 8'h0A) begin
      tag = "R9"; exp_num = 0;
    end
    chk(tag, "mem_we", int'(mem_we), we_e);
    chk(tag, "pc_load", int'(pc_load), pl_e);
    chk(tag, "step_pulse", int'(step_pulse), st_e);
    chk("R7", "pc_value", int'(pc_value), exp_pc);
    // idle cycle with an opcode byte on the bus but valid low: R10, R11
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h41;
    @(posedge clk);
    #1;
    chk("R11", "idle strobes", int'({mem_we, pc_load, step_pulse}), 0);
  endtask

  task automatic put_str(input string s);
    for (int i = 0; i < s.len(); i++) put(s[i]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "mem_we", int'(mem_we), 0);
    chk("R1", "pc_load", int'(pc_load), 0);
    chk("R1", "step_pulse", int'(step_pulse), 0);
    chk("R1", "pc_value", int'(pc_value), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "in_ready", int'(in_ready), 1);

    // R1: first word lands at address 0
    put_str("7C");

    // R5: bare opcode after a word writes number 0
    put("X");
    chk("R5", "bare operand", int'(mem_wdata[10:0]), 0);

    // sweep every opcode character with varied numbers, some above 2047 (R2)
    for (int op = 0; op < 32; op++) begin
      int n;
      n = (op * 613 + 29) % 9000;
      put_str($sformatf("%0d%c ", n, 8'h40 + op));
    end

    // R4 wrap: load address to top, then two words
    put_str("2047a");
    put_str("1B2C");
    chk("R4", "wrapped addr", int'(mem_addr), 0);

    // R10 stray bytes between digits are ignored
    put_str("12#3Q");
    chk("R10", "stray kept digits", int'(mem_wdata[10:0]), 123);

    // R9 whitespace drops partial number
    put_str("99 7K");
    chk("R9", "space clears", int'(mem_wdata[10:0]), 7);
    put_str("45\r8\nL");
    chk("R9", "crlf clears", int'(mem_wdata[10:0]), 0);

    // R6 address set, then R7 pc preset, R8 step
    put_str("300a5D");
    chk("R6", "set addr", int'(mem_addr), 300);
    put_str("1234e");
    chk("R7", "pc preset", int'(pc_value), 1234);
    put_str("77s");
    put("F");
    chk("R8", "step clears number", int'(mem_wdata[10:0]), 0);
    put_str("e");
    chk("R7", "bare preset", int'(pc_value), 0);
    put_str("a@");
    chk("R6", "bare addr", int'(mem_addr), 0);
    chk("R3", "at sign opcode", int'(mem_wdata[15:11]), 0);
    put_str("65535_");
    chk("R2", "wrapped number", int'(mem_wdata[10:0]), 65535 % 2048);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule